// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to eight level-sensitive interrupt requests, screens them with a per-line mask, and ranks them against the lines the processor is already servicing. When an unmasked request outranks everything in service, it raises one interrupt output.

The processor answers with two acknowledge pulses. The first pulse records the winner as in service and freezes the pending picture. The second pulse returns an 8-bit vector: a configurable base plus the line number. Software later retires the service with an end-of-interrupt command. That command can name the line or let the block pick the top in-service line. Optionally the block retires the line itself at the second pulse. In rotating mode, each retired line drops to the bottom of the priority order.

A small write port carries three commands: mask updates, end-of-interrupt or priority commands, and the choice of which register the registered read port shows. The vector base and the two mode bits are static configuration inputs.

Top module: `vic_ctrl`

## Requirements
- R1: After a synchronous reset, `int_out` and `vec_valid` are low, nothing is pending, masked or in service, the read port shows the pending register (so `rd_data` is 0), and priority runs from line 0 (highest) to line 7 (lowest).
- R2: Requests are level-sensitive. Outside an acknowledge cycle, each pending bit copies its `irq_in` bit on every clock. `rd_data` shows the selected register one clock after it changes.
- R3: A mask write (`wr_sel`=0) sets or clears one mask bit. `wr_data[2:0]` names the line and `wr_data[3]` is the new mask value, where 1 means masked. A masked line still shows as pending but never raises `int_out` and is never chosen at acknowledge.
- R4: `int_out` is high only when the best unmasked pending line ranks strictly above every in-service line. An in-service line blocks requests of equal and lower rank.
- R5: On the first `ack` pulse with a valid winner, the winner's in-service bit is set and its pending bit is cleared. The pending register then holds unchanged until the second pulse, and `int_out` stays low for the rest of the acknowledge cycle.
- R6: On the second `ack` pulse, `vec_out` becomes `cfg_base` plus the winning line number, computed modulo 256, and `vec_valid` is high for exactly one clock.
- R7: If no valid winner exists at the first pulse, the vector is `cfg_base`+7 and no in-service bit is set.
- R8: A non-specific end-of-interrupt (`wr_sel`=1, `wr_data[7:6]`=00) clears the highest-ranked in-service bit.
- R9: A specific end-of-interrupt (`wr_sel`=1, `wr_data[7:6]`=01) clears the in-service bit of line `wr_data[2:0]`.
- R10: With `cfg_auto_eoi` high, the winner's in-service bit clears at the second `ack` pulse.
- R11: With `cfg_rotate` high, every end-of-interrupt makes the retired line the lowest priority. This applies to non-specific, specific and automatic retirement.
- R12: A set-lowest command (`wr_sel`=1, `wr_data[7:6]`=10) makes line `wr_data[2:0]` the lowest priority and leaves the in-service bits untouched.
- R13: A read-select write (`wr_sel`=2) chooses the register shown on `rd_data`. `wr_data[0]`=0 selects pending and 1 selects in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Level-sensitive request lines |
| ack | input | 1 | Acknowledge strobe, one clock per pulse |
| wr_en | input | 1 | Command write strobe |
| wr_sel | input | 2 | Command target: 0 mask, 1 end-of-interrupt/priority, 2 read select |
| wr_data | input | 8 | Command payload |
| cfg_base | input | 8 | Vector base added to the line number |
| cfg_auto_eoi | input | 1 | Retire the in-service bit automatically at the second pulse |
| cfg_rotate | input | 1 | Retired line becomes lowest priority |
| int_out | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 8 | Registered vector |
| vec_valid | output | 1 | One-clock strobe marking a new vector |
| rd_data | output | 8 | Registered view of pending or in-service bits |

## Verification
The bench changes the requests between the two acknowledge pulses and expects both the vector and the pending readback to reflect the state captured at the first pulse. A design that kept arbitrating would return the newer line instead. It nests a higher-priority line over one already in service, then checks that equal and lower lines stay blocked. A resolver that compares against pending bits only would raise the interrupt again at once. It walks a rotation sequence in which two lines keep requesting and must alternate. A design that fails to move the lowest-priority pointer on retirement would serve line 0 every time. It also acknowledges with only a masked request present and expects the line-7 vector with no in-service bit. A design that lets the mask leak would set a bit for the masked line.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Target of a command write, decoded from wr_sel.
  typedef enum logic [1:0] {
    WR_MASK  = 2'd0,
    WR_EOI   = 2'd1,
    WR_RDSEL = 2'd2,
    WR_NONE  = 2'd3
  } wr_tgt_e;

  // Operation carried in the top two payload bits of an end-of-interrupt write.
  typedef enum logic [1:0] {
    EOI_NONSPEC = 2'd0,
    EOI_SPEC    = 2'd1,
    EOI_SETLOW  = 2'd2,
    EOI_NOP     = 2'd3
  } eoi_op_e;

  // Acknowledge handshake phase.
  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_WAIT2 = 1'b1
  } ack_st_e;

endpackage

// File: rtl/vic_pending.sv
// Pending-request and mask registers, one slice per request line.
module vic_pending #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               freeze,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               mask_we,
  input  logic [IDX_W-1:0]   mask_idx,
  input  logic               mask_val,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] mask_q
);

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    logic p_r;
    logic m_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_r <= 1'b0;
        m_r <= 1'b0;
      end else begin
        if (clr_en && (clr_idx == IDX_W'(gi))) p_r <= 1'b0;
        else if (!freeze)                      p_r <= irq_in[gi];
        if (mask_we && (mask_idx == IDX_W'(gi))) m_r <= mask_val;
      end
    end
    assign pend_q[gi] = p_r;
    assign mask_q[gi] = m_r;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mask_we)) |-> $stable(mask_q));                  // R3

  AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(freeze) && !$past(clr_en)) |-> $stable(pend_q));  // R5

  AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(freeze) && !$past(clr_en)) |-> (pend_q == $past(irq_in))); // R2

endmodule

// File: rtl/vic_resolver.sv
// Combinational ranking of candidates and in-service lines under a rotating order.
// Rank 0 is the line just above the lowest-priority pointer.
module vic_resolver #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] cand,
  input  logic [N_LINES-1:0] isr,
  input  logic [IDX_W-1:0]   low_ptr,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic               top_valid,
  output logic [IDX_W-1:0]   top_idx,
  output logic               fire
);

  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] win_rank;
  logic [IDX_W-1:0] top_rank;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_rank  = '0;
    top_valid = 1'b0;
    top_idx   = '0;
    top_rank  = '0;
    pos       = '0;
    // Scan from the lowest rank upward, so the last hit is the best one.
    for (int k = N_LINES - 1; k >= 0; k--) begin
      pos = low_ptr + IDX_W'(k + 1);
      if (cand[pos]) begin
        win_valid = 1'b1;
        win_idx   = pos;
        win_rank  = IDX_W'(k);
      end
      if (isr[pos]) begin
        top_valid = 1'b1;
        top_idx   = pos;
        top_rank  = IDX_W'(k);
      end
    end
    fire = win_valid && (!top_valid || (win_rank < top_rank));
  end

endmodule

// File: rtl/vic_inservice.sv
// In-service register and lowest-priority pointer with all retirement paths.
module vic_inservice #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rotate_mode,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               nspec_en,
  input  logic               top_valid,
  input  logic [IDX_W-1:0]   top_idx,
  input  logic               spec_en,
  input  logic [IDX_W-1:0]   spec_idx,
  input  logic               auto_en,
  input  logic [IDX_W-1:0]   auto_idx,
  input  logic               setlow_en,
  input  logic [IDX_W-1:0]   setlow_idx,
  output logic [N_LINES-1:0] isr_q,
  output logic [IDX_W-1:0]   low_ptr_q
);

  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] set_vec;
  logic [IDX_W-1:0]   ptr_d;

  always_comb begin
    clr_vec = '0;
    set_vec = '0;
    ptr_d   = low_ptr_q;
    if (nspec_en && top_valid) clr_vec[top_idx]  = 1'b1;
    if (spec_en)               clr_vec[spec_idx] = 1'b1;
    if (auto_en)               clr_vec[auto_idx] = 1'b1;
    if (set_en)                set_vec[set_idx]  = 1'b1;
    // Later assignments take precedence: explicit command over automatic.
    if (auto_en && rotate_mode)               ptr_d = auto_idx;
    if (nspec_en && top_valid && rotate_mode) ptr_d = top_idx;
    if (spec_en && rotate_mode)               ptr_d = spec_idx;
    if (setlow_en)                            ptr_d = setlow_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      low_ptr_q <= IDX_W'(N_LINES - 1);
    end else begin
      isr_q     <= (isr_q & ~clr_vec) | set_vec;
      low_ptr_q <= ptr_d;
    end
  end

  AST_SPEC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    spec_en |=> (!isr_q[$past(spec_idx)] || $past(set_en && (set_idx == spec_idx))));     // R9

  AST_AUTO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    auto_en |=> (!isr_q[$past(auto_idx)] || $past(set_en && (set_idx == auto_idx))));     // R10

  AST_PTR_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(setlow_en) && !$past(rotate_mode)) |-> $stable(low_ptr_q));  // R12

  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(nspec_en || spec_en || auto_en || setlow_en)) |-> $stable(low_ptr_q)); // R11

endmodule

// File: rtl/vic_ctrl.sv
// Prioritized vectored interrupt controller: top level, acknowledge sequencing
// and command decode.
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               ack,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [VEC_W-1:0]   wr_data,
  input  logic [VEC_W-1:0]   cfg_base,
  input  logic               cfg_auto_eoi,
  input  logic               cfg_rotate,
  output logic               int_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic [N_LINES-1:0] rd_data
);

  localparam int IDX_W = $clog2(N_LINES);

  wr_tgt_e          tgt;
  eoi_op_e          eoi_op;
  logic [IDX_W-1:0] cmd_line;
  logic             unused_wr_bits;

  ack_st_e          st_q;
  logic [IDX_W-1:0] sel_idx_q;
  logic             sel_ok_q;
  logic             rd_sel_q;
  logic             int_q;
  logic [VEC_W-1:0] vec_q;
  logic             vec_valid_q;
  logic [N_LINES-1:0] rd_q;

  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] isr_q;
  logic [IDX_W-1:0]   low_ptr_q;

  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic               top_valid;
  logic [IDX_W-1:0]   top_idx;
  logic               fire;

  logic ack1;
  logic ack2;
  logic eoi_wr;

  assign tgt            = wr_tgt_e'(wr_sel);
  assign eoi_op         = eoi_op_e'(wr_data[VEC_W-1 -: 2]);
  assign cmd_line       = wr_data[IDX_W-1:0];
  assign unused_wr_bits = ^wr_data;

  assign ack1   = ack && (st_q == ACK_IDLE);
  assign ack2   = ack && (st_q == ACK_WAIT2);
  assign eoi_wr = wr_en && (tgt == WR_EOI);

  vic_pending #(.N_LINES(N_LINES)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .freeze   ((st_q == ACK_WAIT2) || ack),
    .clr_en   (ack1 && fire),
    .clr_idx  (win_idx),
    .mask_we  (wr_en && (tgt == WR_MASK)),
    .mask_idx (cmd_line),
    .mask_val (wr_data[IDX_W]),
    .pend_q   (pend_q),
    .mask_q   (mask_q)
  );

  vic_resolver #(.N_LINES(N_LINES)) u_res (
    .cand      (pend_q & ~mask_q),
    .isr       (isr_q),
    .low_ptr   (low_ptr_q),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .top_valid (top_valid),
    .top_idx   (top_idx),
    .fire      (fire)
  );

  vic_inservice #(.N_LINES(N_LINES)) u_isr (
    .clk         (clk),
    .rst         (rst),
    .rotate_mode (cfg_rotate),
    .set_en      (ack1 && fire),
    .set_idx     (win_idx),
    .nspec_en    (eoi_wr && (eoi_op == EOI_NONSPEC)),
    .top_valid   (top_valid),
    .top_idx     (top_idx),
    .spec_en     (eoi_wr && (eoi_op == EOI_SPEC)),
    .spec_idx    (cmd_line),
    .auto_en     (ack2 && cfg_auto_eoi && sel_ok_q),
    .auto_idx    (sel_idx_q),
    .setlow_en   (eoi_wr && (eoi_op == EOI_SETLOW)),
    .setlow_idx  (cmd_line),
    .isr_q       (isr_q),
    .low_ptr_q   (low_ptr_q)
  );

  // Acknowledge sequencing and registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ACK_IDLE;
      sel_idx_q   <= '0;
      sel_ok_q    <= 1'b0;
      rd_sel_q    <= 1'b0;
      int_q       <= 1'b0;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
      rd_q        <= '0;
    end else begin
      vec_valid_q <= 1'b0;
      if (ack1) begin
        st_q      <= ACK_WAIT2;
        sel_ok_q  <= fire;
        sel_idx_q <= fire ? win_idx : IDX_W'(N_LINES - 1);
      end else if (ack2) begin
        st_q        <= ACK_IDLE;
        vec_q       <= cfg_base + VEC_W'(sel_idx_q);
        vec_valid_q <= 1'b1;
      end
      if (wr_en && (tgt == WR_RDSEL)) rd_sel_q <= wr_data[0];
      int_q <= fire && (st_q == ACK_IDLE) && !ack;
      rd_q  <= rd_sel_q ? isr_q : pend_q;
    end
  end

  assign int_out   = int_q;
  assign vec_out   = vec_q;
  assign vec_valid = vec_valid_q;
  assign rd_data   = rd_q;

  AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(pend_q & ~mask_q)));                         // R3

  AST_VEC_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(ack) && ($past(st_q) == ACK_WAIT2)));          // R6

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack1 && fire) |=> (isr_q[$past(win_idx)] && !pend_q[$past(win_idx)])); // R5

  AST_NO_WIN_NO_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack1 && !fire && !wr_en) |=> (isr_q == $past(isr_q)));              // R7

  AST_INT_QUIET_IN_ACK: assert property (@(posedge clk) disable iff (rst)
    (st_q == ACK_WAIT2) |-> !int_out);                                  // R5

endmodule

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  // Each entry: {request pattern, expected vector with base 0x08, fixed priority}.
  localparam int NVEC = 8;
  localparam logic [15:0] VEC_TBL [NVEC] = '{
    16'h01_08, 16'h80_0F, 16'hA4_0A, 16'hF0_0C,
    16'h12_09, 16'hFF_08, 16'h60_0D, 16'h48_0B
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_in;
  logic       ack;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] cfg_base;
  logic       cfg_auto_eoi;
  logic       cfg_rotate;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic [7:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vic_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .irq_in       (irq_in),
    .ack          (ack),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .cfg_base     (cfg_base),
    .cfg_auto_eoi (cfg_auto_eoi),
    .cfg_rotate   (cfg_rotate),
    .int_out      (int_out),
    .vec_out      (vec_out),
    .vec_valid    (vec_valid),
    .rd_data      (rd_data)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  // Select a register for the read port and return what it shows.
  task automatic read_reg(input logic sel, output logic [7:0] val);
    cmd(2'd2, {7'b0, sel});
    step();
    val = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; irq_in = 8'h00; ack = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
    wr_data = 8'h00; cfg_base = 8'h08; cfg_auto_eoi = 1'b0; cfg_rotate = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk("R1", "int_out after reset", int_out, 0);
    chk("R1", "vec_valid after reset", vec_valid, 0);
    chk("R1", "rd_data after reset", rd_data, 0);

    // Table walk: fixed priority, vector formation, blocking by in-service line
    for (int i = 0; i < NVEC; i++) begin
      irq_in = VEC_TBL[i][15:8];
      step(); step();
      chk("R4", "int_out with pending request", int_out, 1);
      pulse_ack();
      chk("R5", "int_out after first pulse", int_out, 0);
      pulse_ack();
      chk("R6", "vec_valid after second pulse", vec_valid, 1);
      chk("R6", "vector from table", vec_out, VEC_TBL[i][7:0]);
      step();
      chk("R6", "vec_valid one clock only", vec_valid, 0);
      chk("R4", "equal/lower blocked by in-service", int_out, 0);
      irq_in = 8'h00;
      step();
      cmd(2'd1, 8'h00);
      step(); step();
    end

    // R2 / R13: level following and read selection
    irq_in = 8'h5A;
    step(); step();
    chk("R2", "pending follows requests", rd_data, 8'h5A);
    read_reg(1'b1, rv);
    chk("R13", "in-service view empty", rv, 8'h00);
    read_reg(1'b0, rv);
    chk("R13", "pending view restored", rv, 8'h5A);
    irq_in = 8'h00;
    step(); step(); step();
    chk("R2", "withdrawn request drops interrupt", int_out, 0);
    chk("R2", "withdrawn request clears pending", rd_data, 8'h00);

    // R3 / R7: masked line, then acknowledge with no valid winner
    cfg_base = 8'h40;
    cmd(2'd0, 8'h0B);
    irq_in = 8'h08;
    step(); step(); step();
    chk("R3", "masked line raises no interrupt", int_out, 0);
    chk("R3", "masked line still pending", rd_data, 8'h08);
    pulse_ack();
    pulse_ack();
    chk("R7", "no-winner vector is base+7", vec_out, 8'h47);
    read_reg(1'b1, rv);
    chk("R7", "no in-service bit set", rv, 8'h00);
    read_reg(1'b0, rv);
    cmd(2'd0, 8'h03);
    step(); step();
    chk("R3", "unmasked line raises interrupt", int_out, 1);
    irq_in = 8'h00;
    cfg_base = 8'h08;
    step(); step();

    // R4 / R8 / R9: nesting and both EOI forms
    irq_in = 8'h20;
    step(); step();
    pulse_ack(); pulse_ack();
    chk("R6", "vector for line 5", vec_out, 8'h0D);
    irq_in = 8'h24;
    step(); step();
    chk("R4", "higher line preempts in-service", int_out, 1);
    pulse_ack(); pulse_ack();
    chk("R6", "vector for line 2", vec_out, 8'h0A);
    step(); step();
    chk("R4", "both lines blocked while in service", int_out, 0);
    read_reg(1'b1, rv);
    chk("R5", "two lines in service", rv, 8'h24);
    irq_in = 8'h00;
    step();
    cmd(2'd1, 8'h00);
    read_reg(1'b1, rv);
    chk("R8", "non-specific EOI clears top line", rv, 8'h20);
    cmd(2'd1, 8'h45);
    read_reg(1'b1, rv);
    chk("R9", "specific EOI clears line 5", rv, 8'h00);
    read_reg(1'b0, rv);

    // R5: freeze between the pulses
    irq_in = 8'h04;
    step(); step();
    pulse_ack();
    irq_in = 8'h01;
    step();
    chk("R5", "int_out low during acknowledge", int_out, 0);
    read_reg(1'b0, rv);
    chk("R5", "pending frozen with winner cleared", rv, 8'h00);
    pulse_ack();
    chk("R5", "vector uses frozen winner", vec_out, 8'h0A);
    irq_in = 8'h00;
    step();
    cmd(2'd1, 8'h42);
    read_reg(1'b1, rv);
    chk("R9", "specific EOI clears line 2", rv, 8'h00);
    read_reg(1'b0, rv);

    // R10: automatic end-of-interrupt
    cfg_auto_eoi = 1'b1;
    irq_in = 8'h08;
    step(); step();
    pulse_ack();
    read_reg(1'b1, rv);
    chk("R5", "in-service set at first pulse", rv, 8'h08);
    pulse_ack();
    chk("R6", "vector for line 3", vec_out, 8'h0B);
    irq_in = 8'h00;
    step();
    read_reg(1'b1, rv);
    chk("R10", "auto EOI clears in-service", rv, 8'h00);
    read_reg(1'b0, rv);
    cfg_auto_eoi = 1'b0;

    // R11: rotation on end-of-interrupt, two lines requesting throughout
    do_reset();
    cfg_rotate = 1'b1;
    irq_in = 8'h03;
    step(); step();
    pulse_ack(); pulse_ack();
    chk("R11", "first service goes to line 0", vec_out, 8'h08);
    cmd(2'd1, 8'h00);
    step(); step();
    chk("R11", "line 1 raises after rotation", int_out, 1);
    pulse_ack(); pulse_ack();
    chk("R11", "rotated winner is line 1", vec_out, 8'h09);
    cmd(2'd1, 8'h00);
    step(); step();
    pulse_ack(); pulse_ack();
    chk("R11", "line 0 wins again after line 1 retires", vec_out, 8'h08);
    irq_in = 8'h00;
    step();
    cmd(2'd1, 8'h00);
    cfg_rotate = 1'b0;

    // R12: explicit lowest-priority setting, after a reset with activity
    do_reset();
    chk("R1", "rd_data after second reset", rd_data, 0);
    chk("R1", "int_out after second reset", int_out, 0);
    cmd(2'd1, 8'h84);
    irq_in = 8'h41;
    step(); step();
    pulse_ack(); pulse_ack();
    chk("R12", "line 6 outranks line 0 when 4 is lowest", vec_out, 8'h0E);
    irq_in = 8'h00;
    step();
    cmd(2'd1, 8'h46);
    read_reg(1'b1, rv);
    chk("R12", "in-service clean after specific EOI", rv, 8'h00);

    summary();
    $finish;
  end

endmodule